// File: doc/BRIEF.md
# Self-Locating Bus Window Controller

This block lets an add-in card find a free memory window on a shared parallel host bus with no switches or jumpers. After a hard reset it picks the first of a fixed list of candidate windows, stays there for a set number of clocks, then moves to the next one. After the last window it starts again at the first, and it keeps going round until the host confirms the window.

While it searches, the block only listens. Another device may answer the same addresses, so it drives nothing. It snoops single-cycle host writes. The host unlocks the card with an ordered run of byte writes into the current window. When the last write of that run lands, the block stops moving, keeps the window it is on, and turns on its read and write handshake. From then on it can answer accesses that fall in its window.

The block also tells a soft reset of the card from a power-on reset. The power-on reset clears everything. A soft reset keeps the search position, the unlock progress and the lock. It only mutes the handshake while it is held.

Top module: `bus_window_seeker`

## Requirements
- R1: While `por_n` is low, and in the first cycle after it is released, `locked`, `hs_en`, `data_oe` and `rdy_oe` are 0 and `range_idx` is 0.
- R2: While unlocked, `range_idx` moves to the next value exactly once every `DWELL` clocks (default 4096). `win_base` always equals `BASE_START + range_idx * 2**WIN_LOG2` (defaults 0xC0000 and 14).
- R3: After index `N_RANGES-1` (default 7), the next advance goes to index 0.
- R4: While unlocked, `hs_en`, `data_oe` and `rdy_oe` stay 0, whatever reads or writes hit the window.
- R5: The unlock key is eight writes, in order, to window offsets 0 to 7. Step i carries data `(0x5A + 0x1D*i) mod 256`, which gives 5A, 77, 94, B1, CE, EB, 08 and 25. `locked` is 1 at the first sample after the clock edge that takes the eighth write.
- R6: A write inside the window that is not the next expected (offset, data) pair sends the key matcher back to step 0. A lone wrong write never locks the block.
- R7: Reads, and writes outside the current window, leave the key progress unchanged.
- R8: A soft reset (`soft_rst` high) leaves the range index, the key progress and `locked` unchanged, and the matcher ignores writes while it is held. While `soft_rst` is high, `hs_en` and `rdy_oe` are 0.
- R9: A range advance puts the matcher back at step 0, so key steps split across two windows do not lock.
- R10: Once locked, `range_idx` and `win_base` stay fixed for as long as no hard reset comes.
- R11: When locked and not in soft reset, `hs_en` is 1. `rdy_oe` is 1 for a read or write that hits the window. `data_oe` is 1 only for a read that hits the window.
- R12: A hard reset while locked returns the block to searching at index 0. A hard reset in the middle of a key clears the partial progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Hard (power-on) reset, asynchronous, active low |
| soft_rst | input | 1 | Soft card reset, synchronous, active high |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 20 | Host byte address |
| bus_wdata | input | 8 | Host write data |
| locked | output | 1 | Window confirmed by the host |
| range_idx | output | 3 | Index of the current candidate window |
| win_base | output | 20 | Base address of the current window |
| hs_en | output | 1 | Read/write handshake enabled |
| data_oe | output | 1 | Drive read data onto the bus |
| rdy_oe | output | 1 | Drive the ready/wait handshake |

## Verification
The key matcher gets several kinds of write pattern. A clean key tells a working matcher from a dead one. Stray wrong bytes and wrong offsets show that lone writes cannot unlock the block. A key broken in the middle tells a real restart from a matcher that only pauses. A key with reads and out-of-window writes mixed in shows that foreign traffic is ignored. A key whose first half falls in one window and second half in the next shows that an advance clears progress. Keys cut by a soft reset and by a hard reset show which reset keeps progress and which clears it. The interval between advances, the wrap from the last index, and the frozen window after lock are measured directly on `range_idx`.

// File: rtl/bwin_pkg.sv
package bwin_pkg;

   // Byte expected at key step i: seed plus i times stride, modulo 256.
   function automatic logic [7:0] key_byte(input logic [7:0] seed,
                                           input logic [7:0] stride,
                                           input int unsigned i);
      key_byte = 8'(int'(seed) + int'(stride) * int'(i));
   endfunction

endpackage

// File: rtl/bwin_window_decode.sv
module bwin_window_decode #(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned WIN_LOG2   = 14,
   parameter int unsigned IDX_W      = 3,
   parameter int unsigned BASE_START = 32'h000C_0000
) (
   input  logic [IDX_W-1:0]    idx_i,
   input  logic [ADDR_W-1:0]   addr_i,
   output logic [ADDR_W-1:0]   base_o,
   output logic                hit_o,
   output logic [WIN_LOG2-1:0] offset_o
);
   localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;

   assign base_o   = ADDR_W'(BASE_START) + (ADDR_W'(idx_i) << WIN_LOG2);
   assign hit_o    = (addr_i[ADDR_W-1:WIN_LOG2] == base_o[ADDR_W-1:WIN_LOG2]);
   assign offset_o = addr_i[WIN_LOG2-1:0];

   if (TAG_W < 1) begin : g_bad_tag
      $error("bwin_window_decode: WIN_LOG2 must be below ADDR_W");
   end
endmodule

// File: rtl/bwin_hunt_stepper.sv
module bwin_hunt_stepper #(
   parameter int unsigned N_RANGES = 8,
   parameter int unsigned DWELL    = 4096,
   parameter int unsigned IDX_W    = 3
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             lock_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             advance_o
);
   localparam int unsigned CNT_W = (DWELL > 2) ? $clog2(DWELL) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_RANGES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] idx_nxt;

   if ((1 << IDX_W) == N_RANGES) begin : g_wrap_pow2
      assign idx_nxt = idx_o + 1'b1;
   end else begin : g_wrap_cmp
      assign idx_nxt = (idx_o == IDX_LAST) ? '0 : idx_o + 1'b1;
   end

   assign advance_o = !lock_i && (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
         idx_o <= '0;
      end else if (!lock_i) begin
         if (advance_o) begin
            cnt_q <= '0;
            idx_o <= idx_nxt;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   if (DWELL < 2) begin : g_bad_dwell
      $error("bwin_hunt_stepper: DWELL must be at least 2");
   end
   if (N_RANGES < 2 || N_RANGES > (1 << IDX_W)) begin : g_bad_ranges
      $error("bwin_hunt_stepper: N_RANGES out of range for IDX_W");
   end

   // R2: no move between dwell ends
   a_r2_idx_steady: assert property (@(posedge clk) disable iff (!por_n)
      (!advance_o) |=> $stable(idx_o));
   // R3: last range wraps to the first
   a_r3_wrap_first: assert property (@(posedge clk) disable iff (!por_n)
      (advance_o && idx_o == IDX_LAST) |=> (idx_o == '0));
   // R10: locked window stays put
   a_r10_hold_idx: assert property (@(posedge clk) disable iff (!por_n)
      lock_i |=> $stable(idx_o));
endmodule

// File: rtl/bwin_key_matcher.sv
module bwin_key_matcher #(
   parameter int unsigned WIN_LOG2   = 14,
   parameter int unsigned KEY_LEN    = 8,
   parameter logic [7:0]  KEY_SEED   = 8'h5A,
   parameter logic [7:0]  KEY_STRIDE = 8'h1D
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                soft_rst_i,
   input  logic                advance_i,
   input  logic                wr_i,
   input  logic                hit_i,
   input  logic [WIN_LOG2-1:0] offset_i,
   input  logic [7:0]          wdata_i,
   output logic                locked_o
);
   import bwin_pkg::*;

   localparam int unsigned STEP_W = $clog2(KEY_LEN);
   localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(KEY_LEN - 1);

   logic [STEP_W-1:0] step_q;
   logic              wr_hit, match;

   assign wr_hit = wr_i && hit_i && !soft_rst_i;
   assign match  = (offset_i == WIN_LOG2'(step_q)) &&
                   (wdata_i == key_byte(KEY_SEED, KEY_STRIDE, int'(step_q)));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         step_q   <= '0;
         locked_o <= 1'b0;
      end else if (!locked_o) begin
         if (advance_i) begin
            step_q <= '0;
         end else if (wr_hit) begin
            if (!match) begin
               step_q <= '0;
            end else if (step_q == STEP_LAST) begin
               step_q   <= '0;
               locked_o <= 1'b1;
            end else begin
               step_q <= step_q + 1'b1;
            end
         end
      end
   end

   if (KEY_LEN < 2 || KEY_LEN > (1 << WIN_LOG2)) begin : g_bad_key
      $error("bwin_key_matcher: KEY_LEN must fit in the window");
   end
   if ((1 << STEP_W) != KEY_LEN) begin : g_bad_key_pow2
      $error("bwin_key_matcher: KEY_LEN must be a power of two");
   end

   // R6: wrong write inside window restarts the key
   a_r6_restart: assert property (@(posedge clk) disable iff (!por_n)
      (!locked_o && wr_hit && !match) |=> (step_q == '0) && !locked_o);
   // R9: range advance clears key progress
   a_r9_adv_clear: assert property (@(posedge clk) disable iff (!por_n)
      advance_i |=> (step_q == '0) && !locked_o);
   // R7: no write in window, no progress change
   a_r7_no_touch: assert property (@(posedge clk) disable iff (!por_n)
      (!advance_i && !(wr_i && hit_i)) |=> $stable(step_q));
   // R8: soft reset keeps progress and lock
   a_r8_soft_keep: assert property (@(posedge clk) disable iff (!por_n)
      (soft_rst_i && !advance_i) |=> $stable(step_q) && $stable(locked_o));
   // R10: lock is sticky
   a_r10_sticky: assert property (@(posedge clk) disable iff (!por_n)
      locked_o |=> locked_o);
endmodule

// File: rtl/bus_window_seeker.sv
module bus_window_seeker #(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned WIN_LOG2   = 14,
   parameter int unsigned N_RANGES   = 8,
   parameter int unsigned BASE_START = 32'h000C_0000,
   parameter int unsigned DWELL      = 4096,
   parameter int unsigned KEY_LEN    = 8,
   parameter logic [7:0]  KEY_SEED   = 8'h5A,
   parameter logic [7:0]  KEY_STRIDE = 8'h1D,
   localparam int unsigned IDX_W     = $clog2(N_RANGES)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              soft_rst,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic              locked,
   output logic [IDX_W-1:0]  range_idx,
   output logic [ADDR_W-1:0] win_base,
   output logic              hs_en,
   output logic              data_oe,
   output logic              rdy_oe
);
   logic                advance;
   logic                hit;
   logic [WIN_LOG2-1:0] offset;

   bwin_hunt_stepper #(
      .N_RANGES(N_RANGES), .DWELL(DWELL), .IDX_W(IDX_W)
   ) u_stepper (
      .clk(clk), .por_n(por_n), .lock_i(locked),
      .idx_o(range_idx), .advance_o(advance)
   );

   bwin_window_decode #(
      .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .IDX_W(IDX_W), .BASE_START(BASE_START)
   ) u_decode (
      .idx_i(range_idx), .addr_i(bus_addr),
      .base_o(win_base), .hit_o(hit), .offset_o(offset)
   );

   bwin_key_matcher #(
      .WIN_LOG2(WIN_LOG2), .KEY_LEN(KEY_LEN),
      .KEY_SEED(KEY_SEED), .KEY_STRIDE(KEY_STRIDE)
   ) u_matcher (
      .clk(clk), .por_n(por_n), .soft_rst_i(soft_rst), .advance_i(advance),
      .wr_i(bus_wr), .hit_i(hit), .offset_i(offset), .wdata_i(bus_wdata),
      .locked_o(locked)
   );

   assign hs_en   = locked && !soft_rst;
   assign rdy_oe  = hs_en && hit && (bus_rd || bus_wr);
   assign data_oe = hs_en && hit && bus_rd;

   if (BASE_START % (1 << WIN_LOG2) != 0) begin : g_bad_align
      $error("bus_window_seeker: BASE_START must be window aligned");
   end
   if (64'(BASE_START) + 64'(N_RANGES) * (64'd1 << WIN_LOG2) > (64'd1 << ADDR_W)) begin : g_bad_span
      $error("bus_window_seeker: candidate windows exceed the address space");
   end

   // R4: silent on the bus while searching
   a_r4_silent: assert property (@(posedge clk) disable iff (!por_n)
      !locked |-> !data_oe && !rdy_oe && !hs_en);
   // R8: soft reset mutes the handshake
   a_r8_soft_mute: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |-> !hs_en && !rdy_oe);
   // R10: base frozen once locked
   a_r10_base_hold: assert property (@(posedge clk) disable iff (!por_n)
      locked |=> $stable(win_base));
endmodule

// File: tb/tb_bus_window_seeker.sv
`timescale 1ns/1ps
module tb_bus_window_seeker;
   localparam int unsigned ADDR_W = 20;
   localparam int unsigned WINSZ  = 16384;
   localparam int unsigned BASE0  = 32'h000C_0000;
   localparam int unsigned DWELL  = 4096;

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic              soft_rst = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [7:0]        bus_wdata = '0;
   logic              locked;
   logic [2:0]        range_idx;
   logic [ADDR_W-1:0] win_base;
   logic              hs_en, data_oe, rdy_oe;

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];
   logic prev_locked = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bus_window_seeker dut (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .locked(locked), .range_idx(range_idx), .win_base(win_base),
      .hs_en(hs_en), .data_oe(data_oe), .rdy_oe(rdy_oe)
   );

   function automatic logic [7:0] kb(input int i);
      kb = 8'(32'h5A + 32'h1D * i);
   endfunction

   function automatic logic [ADDR_W-1:0] base_of(input int idx);
      base_of = ADDR_W'(BASE0 + idx * WINSZ);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard driver side: expected range index at the next lock
   task automatic expect_lock(input int idx);
      exp_q.push_back(idx);
   endtask

   // scoreboard monitor side
   always @(negedge clk) begin
      if (!por_n) begin
         prev_locked = 1'b0;
      end else begin
         if (locked && !prev_locked) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R6 unexpected lock actual=1 expected=0 at range %0d", range_idx);
            end else begin
               chk("R5 lock range", 32'(range_idx), 32'(exp_q.pop_front()));
            end
         end
         prev_locked = locked;
      end
   end

   task automatic hard_reset();
      @(negedge clk); por_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
   endtask

   task automatic bw(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic send_keys(input int lo, input int hi);
      for (int i = lo; i <= hi; i++) bw(base_of(int'(range_idx)) + ADDR_W'(i), kb(i));
   endtask

   task automatic sync_edge();
      logic [2:0] s;
      s = range_idx;
      while (range_idx == s) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(negedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int c;
      logic [2:0] s;
      repeat (4) @(negedge clk);
      chk("R1 locked in reset", 32'(locked), 0);
      chk("R1 idx in reset", 32'(range_idx), 0);
      por_n = 1'b1;
      @(negedge clk);
      chk("R1 locked", 32'(locked), 0);
      chk("R1 idx", 32'(range_idx), 0);
      chk("R1 hs_en", 32'(hs_en), 0);
      chk("R1 oe", 32'({data_oe, rdy_oe}), 0);

      // R2 dwell length and base formula
      sync_edge();
      s = range_idx; c = 0;
      while (range_idx == s) begin @(negedge clk); c++; end
      chk("R2 dwell clocks", 32'(c), DWELL);
      chk("R2 next idx", 32'(range_idx), 32'(3'(s + 3'd1)));
      chk("R2 win_base", 32'(win_base), 32'(base_of(int'(range_idx))));

      // R4 silent while searching
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = base_of(int'(range_idx)) + 20'd3;
      #1;
      chk("R4 read oe", 32'({hs_en, data_oe, rdy_oe}), 0);
      bus_rd = 1'b0; bus_wr = 1'b1; bus_wdata = 8'h11;
      #1;
      chk("R4 write oe", 32'({hs_en, data_oe, rdy_oe}), 0);
      @(negedge clk); bus_wr = 1'b0;

      // R3 wrap
      while (range_idx != 3'd7) @(negedge clk);
      sync_edge();
      chk("R3 wrap to 0", 32'(range_idx), 0);

      // R6 stray wrong writes do not lock
      bw(base_of(int'(range_idx)) + 20'd0, kb(0) ^ 8'h01);
      bw(base_of(int'(range_idx)) + 20'd1, kb(1));
      bw(base_of(int'(range_idx)) + 20'd5, kb(0));
      repeat (2) @(negedge clk);
      chk("R6 stray writes no lock", 32'(locked), 0);
      // R6 key broken midway restarts
      send_keys(0, 3);
      bw(base_of(int'(range_idx)) + 20'd4, 8'h00);
      send_keys(4, 7);
      repeat (2) @(negedge clk);
      chk("R6 broken key no lock", 32'(locked), 0);

      // R9 key split across a range advance
      sync_edge();
      repeat (DWELL - 40) @(negedge clk);
      send_keys(0, 3);
      sync_edge();
      send_keys(4, 7);
      repeat (2) @(negedge clk);
      chk("R9 split key no lock", 32'(locked), 0);

      // R8 soft reset keeps progress; R7 foreign traffic ignored
      sync_edge();
      send_keys(0, 3);
      @(negedge clk); soft_rst = 1'b1;
      #1 chk("R8 hs_en in soft reset", 32'(hs_en), 0);
      bw(base_of(int'(range_idx)) + 20'd0, kb(0));
      @(negedge clk); soft_rst = 1'b0;
      chk("R8 no lock yet", 32'(locked), 0);
      bw(ADDR_W'(BASE0 - 16), kb(4));
      @(negedge clk); bus_rd = 1'b1; bus_addr = base_of(int'(range_idx)) + 20'd4;
      @(negedge clk); bus_rd = 1'b0;
      expect_lock(int'(range_idx));
      send_keys(4, 7);
      @(negedge clk);
      chk("R5 R7 locked after key", 32'(locked), 1);

      // R10 window frozen
      s = range_idx;
      repeat (DWELL + 100) @(negedge clk);
      chk("R10 idx held", 32'(range_idx), 32'(s));
      chk("R10 base held", 32'(win_base), 32'(base_of(int'(s))));

      // R11 handshake when locked
      bus_rd = 1'b1; bus_addr = base_of(int'(s)) + 20'd9;
      #1;
      chk("R11 read hit", 32'({hs_en, data_oe, rdy_oe}), 3'b111);
      bus_addr = base_of(int'(s)) - 20'd1;
      #1;
      chk("R11 read miss", 32'({hs_en, data_oe, rdy_oe}), 3'b100);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = base_of(int'(s)) + 20'd2; bus_wdata = 8'h00;
      #1;
      chk("R11 write hit", 32'({data_oe, rdy_oe}), 2'b01);
      @(negedge clk); bus_wr = 1'b0;

      // R8 soft reset while locked
      soft_rst = 1'b1; bus_rd = 1'b1; bus_addr = base_of(int'(s));
      #1;
      chk("R8 mute while locked", 32'({hs_en, rdy_oe, data_oe}), 0);
      repeat (2) @(negedge clk);
      chk("R8 lock kept", 32'(locked), 1);
      soft_rst = 1'b0; bus_rd = 1'b0;
      @(negedge clk);
      chk("R8 hs_en back", 32'(hs_en), 1);

      // R12 hard reset unlocks and clears progress
      hard_reset();
      @(negedge clk);
      chk("R12 unlocked", 32'(locked), 0);
      chk("R12 idx 0", 32'(range_idx), 0);
      chk("R12 hs_en", 32'(hs_en), 0);
      send_keys(0, 3);
      hard_reset();
      send_keys(4, 7);
      repeat (2) @(negedge clk);
      chk("R12 progress cleared", 32'(locked), 0);

      // R5 clean key after all that
      expect_lock(int'(range_idx));
      send_keys(0, 7);
      @(negedge clk);
      chk("R5 clean key locks", 32'(locked), 1);
      repeat (2) @(negedge clk);
      chk("R5 all expected locks seen", 32'(exp_q.size()), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule